// File: doc/BRIEF.md
# Multi-Channel Compare Timer

An up-counting timer with a small word-addressed register bank. A counter of `CNT_W` bits advances on ticks taken from one of two tick inputs (a fast tick already in the block's clock domain, or a slow tick that is synchronized and edge-detected), thinned by a 12-bit prescaler. Three compare registers raise sticky match flags. Wrapping past all-ones raises a rollover flag. One interrupt line reports any flag whose enable is set, but only while the timer is enabled.

The counter runs in one of two modes. In free-run mode it counts to all-ones and wraps. In restart mode it returns to zero after it has reached compare register 1. Software can reset the block by writing the control register. The control, prescaler, status and enable registers keep the state that an interrupt handler or a driver needs. The two capture slots always read zero.

Top module: `tick_compare_timer`

## Requirements
- R1: Word offsets: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture slots, 9 counter. The capture slots and the counter cannot be written, and the capture slots read zero. Any other offset reads zero and ignores writes.
- R2: Control bits 2, 4 and 10 to 14 are dropped on write and read back zero. Bit 15 (software reset) never reads back as 1.
- R3: Control bits 8:6 pick the tick source. Code 001 or 010 picks the fast tick, code 100 picks the slow tick, and every other code picks no tick, so the counter holds.
- R4: The prescaler keeps its low 12 bits. The counter advances once per (prescaler+1) selected ticks.
- R5: With control bit 9 = 1 (free-run), the counter counts up to all-ones, wraps to zero and sets status bit 5 (rollover).
- R6: Status bits 0, 1 and 2 are set on the advance that brings the counter to the value of compare 1, 2 or 3. This happens whether or not the matching interrupt is enabled.
- R7: Writing 1 to a status bit 5:0 clears it. Writing 0 leaves it unchanged.
- R8: `irq` is high exactly when control bit 0 is set and some status bit is set together with the same bit of the interrupt-enable register (low six bits kept).
- R9: With control bit 9 = 0 (restart), the counter goes to zero on the advance after it equals compare 1, and no rollover flag is set.
- R10: In restart mode, a write to compare 1 clears the counter to zero.
- R11: While control bit 0 is 0 the counter holds. If bit 0 goes from 0 to 1 in a write that also sets bit 1 (enable mode), the counter is cleared. If bit 1 is 0, counting continues from the held value.
- R12: A control write with bit 15 set clears control bits 0 to 5 and 15 and keeps the other written bits. It zeroes the prescaler, status, interrupt enable and counter, and sets every compare register to all-ones.
- R13: After hardware reset, control, prescaler, status, interrupt enable, counter and capture slots read zero, the compare registers read all-ones, and `irq` is low.
- R14: With code 100, each rising edge of `slow_tick` counts as one tick after a two-flop synchronizer. The fast tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| fast_tick | input | 1 | Tick enable in the `clk` domain |
| slow_tick | input | 1 | Asynchronous slow tick level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit counter. This puts the all-ones wrap, the rollover flag and a compare-1 match at the top value within a few hundred ticks, which a 32-bit counter could never reach. The prescaler keeps its full 12 bits and the synchronizer keeps its two stages. This exercises register masking and slow-tick latency at their default shape. The fast tick is pulsed one cycle at a time, so every expected count follows exactly from the number of pulses.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
   localparam int unsigned BUS_W    = 32;
   localparam int unsigned NUM_CMP  = 3;
   localparam int unsigned FLAG_W   = 6;
   localparam int unsigned ROV_BIT  = 5;

   // word offsets
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_PRE  = 1;
   localparam int unsigned OFS_STS  = 2;
   localparam int unsigned OFS_IER  = 3;
   localparam int unsigned OFS_CMP  = 4;
   localparam int unsigned OFS_CAP  = 7;
   localparam int unsigned NUM_CAP  = 2;
   localparam int unsigned OFS_CNT  = 9;

   // control fields
   localparam int unsigned C_RUN     = 0;
   localparam int unsigned C_ENMODE  = 1;
   localparam int unsigned C_SRC_LO  = 6;
   localparam int unsigned C_FREERUN = 9;
   localparam int unsigned C_SWR     = 15;

   localparam logic [BUS_W-1:0] CTRL_DROP = 32'h0000_7C14;
   localparam logic [BUS_W-1:0] SWR_CLR   = 32'h0000_803F;

   localparam logic [2:0] SRC_FAST_A = 3'b001;
   localparam logic [2:0] SRC_FAST_B = 3'b010;
   localparam logic [2:0] SRC_SLOW   = 3'b100;
endpackage

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen #(
   parameter int unsigned PRE_W       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [2:0]       src,
   input  logic [PRE_W-1:0] prescale,
   input  logic             fast_tick,
   input  logic             slow_tick,
   output logic             advance
);
   import ctmr_pkg::*;

   localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ctmr_tick_gen: SYNC_STAGES must be at least 2");
      end
      if (PRE_W < 1) begin : g_bad_pre
         $error("ctmr_tick_gen: PRE_W must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;
   logic               slow_edge;
   logic               src_tick;
   logic [PRE_W-1:0]   div_q;
   logic               div_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], slow_tick};
   end

   assign slow_edge = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

   always_comb begin
      case (src)
         SRC_FAST_A, SRC_FAST_B: src_tick = fast_tick;
         SRC_SLOW:               src_tick = slow_edge;
         default:                src_tick = 1'b0;
      endcase
   end

   assign div_done = (div_q >= prescale);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_q <= '0;
      else if (clr)              div_q <= '0;
      else if (run && src_tick) begin
         if (div_done) div_q <= '0;
         else          div_q <= div_q + 1'b1;
      end
   end

   assign advance = run & src_tick & div_done;
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned N_CMP   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        advance,
   input  logic                        freerun,
   input  logic [N_CMP-1:0][CNT_W-1:0] cmp,
   output logic [CNT_W-1:0]            cnt,
   output logic [N_CMP-1:0]            hit,
   output logic                        rov
);
   localparam logic [CNT_W-1:0] TOP = '1;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("ctmr_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic             restart_hit;

   assign restart_hit = !freerun && (cnt_q == cmp[0]);
   assign nxt         = restart_hit ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (advance) cnt_q <= nxt;
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_CMP; gi++) begin : g_match
         assign hit[gi] = advance && !clr && (nxt == cmp[gi]);
      end
   endgenerate

   assign rov = advance && !clr && !restart_hit && (cnt_q == TOP);
   assign cnt = cnt_q;
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned PRE_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              fast_tick,
   input  logic              slow_tick,
   output logic              irq
);
   import ctmr_pkg::*;

   localparam logic [CNT_W-1:0] CMP_RST = '1;

   generate
      if (CNT_W > BUS_W) begin : g_bad_cnt
         $error("tick_compare_timer: CNT_W exceeds bus width");
      end
      if (PRE_W > BUS_W) begin : g_bad_pre
         $error("tick_compare_timer: PRE_W exceeds bus width");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("tick_compare_timer: ADDR_W must reach offset 9");
      end
   endgenerate

   logic [BUS_W-1:0]                  ctrl_q;
   logic [PRE_W-1:0]                  pre_q;
   logic [FLAG_W-1:0]                 sts_q;
   logic [FLAG_W-1:0]                 ier_q;
   logic [NUM_CMP-1:0][CNT_W-1:0]     cmp_q;
   logic [CNT_W-1:0]                  cnt_q;
   logic [NUM_CMP-1:0]                hit;
   logic                              rov;
   logic                              advance;

   // ---------------- write decode ----------------
   logic wr_ctrl, wr_pre, wr_sts, wr_ier;
   logic [NUM_CMP-1:0] wr_cmp;
   logic soft_rst, en_clear, cmp1_clear, cnt_clear;
   logic [BUS_W-1:0] ctrl_wval;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
   assign wr_pre  = wr_en && (addr == ADDR_W'(OFS_PRE));
   assign wr_sts  = wr_en && (addr == ADDR_W'(OFS_STS));
   assign wr_ier  = wr_en && (addr == ADDR_W'(OFS_IER));

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CMP; gc++) begin : g_cmp_dec
         assign wr_cmp[gc] = wr_en && (addr == ADDR_W'(OFS_CMP + gc));
      end
   endgenerate

   assign soft_rst   = wr_ctrl && wdata[C_SWR];
   assign ctrl_wval  = soft_rst ? (wdata & ~CTRL_DROP & ~SWR_CLR)
                                : (wdata & ~CTRL_DROP);
   assign en_clear   = wr_ctrl && !soft_rst && !ctrl_q[C_RUN]
                       && wdata[C_RUN] && wdata[C_ENMODE];
   assign cmp1_clear = wr_cmp[0] && !ctrl_q[C_FREERUN];
   assign cnt_clear  = soft_rst || en_clear || cmp1_clear;

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_wval;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_q <= '0;
      else if (soft_rst) pre_q <= '0;
      else if (wr_pre)   pre_q <= wdata[PRE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ier_q <= '0;
      else if (soft_rst) ier_q <= '0;
      else if (wr_ier)   ier_q <= wdata[FLAG_W-1:0];
   end

   generate
      for (gc = 0; gc < NUM_CMP; gc++) begin : g_cmp_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cmp_q[gc] <= CMP_RST;
            else if (soft_rst)   cmp_q[gc] <= CMP_RST;
            else if (wr_cmp[gc]) cmp_q[gc] <= wdata[CNT_W-1:0];
         end
      end
   endgenerate

   // status: events win over a same-cycle clear
   logic [FLAG_W-1:0] sts_set;
   logic [FLAG_W-1:0] sts_clr;

   always_comb begin
      sts_set                = '0;
      sts_set[NUM_CMP-1:0]   = hit;
      sts_set[ROV_BIT]       = rov;
      sts_clr                = wr_sts ? wdata[FLAG_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sts_q <= '0;
      else if (soft_rst) sts_q <= '0;
      else               sts_q <= (sts_q & ~sts_clr) | sts_set;
   end

   // ---------------- datapath ----------------
   ctmr_tick_gen #(
      .PRE_W       (PRE_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cnt_clear),
      .run       (ctrl_q[C_RUN]),
      .src       (ctrl_q[C_SRC_LO +: 3]),
      .prescale  (pre_q),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .advance   (advance)
   );

   ctmr_counter #(
      .CNT_W (CNT_W),
      .N_CMP (NUM_CMP)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cnt_clear),
      .advance (advance),
      .freerun (ctrl_q[C_FREERUN]),
      .cmp     (cmp_q),
      .cnt     (cnt_q),
      .hit     (hit),
      .rov     (rov)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CTRL))      rdata = ctrl_q;
      else if (addr == ADDR_W'(OFS_PRE))  rdata = BUS_W'(pre_q);
      else if (addr == ADDR_W'(OFS_STS))  rdata = BUS_W'(sts_q);
      else if (addr == ADDR_W'(OFS_IER))  rdata = BUS_W'(ier_q);
      else if (addr == ADDR_W'(OFS_CNT))  rdata = BUS_W'(cnt_q);
      else begin
         for (int k = 0; k < NUM_CMP; k++) begin
            if (addr == ADDR_W'(OFS_CMP + k)) rdata = BUS_W'(cmp_q[k]);
         end
      end
   end

   assign irq = ctrl_q[C_RUN] && |(sts_q & ier_q);
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             irq,
   input logic [31:0]      ctrl_q,
   input logic [5:0]       sts_q,
   input logic [CNT_W-1:0] cnt_q
);
   // R2
   ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & 32'h0000_FC14) == 32'h0);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[0] |-> !irq);

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[0] && !wr_en) |=> $stable(cnt_q));

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && !wr_en) |=> (cnt_q == $past(cnt_q)
                                 || cnt_q == CNT_W'($past(cnt_q) + 1'b1)
                                 || cnt_q == '0));

   // R5
   rov_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[5]) |-> (cnt_q == '0));
endmodule

bind tick_compare_timer ctmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .irq    (irq),
   .ctrl_q (ctrl_q),
   .sts_q  (sts_q),
   .cnt_q  (cnt_q)
);

// File: tb/tick_compare_timer_bench.sv
module tick_compare_timer_bench;
   localparam int CW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        fast_tick = 1'b0;
   logic        slow_tick = 1'b0;
   wire  [31:0] rdata;
   wire         irq;

   always #5 clk = ~clk;

   tick_compare_timer #(.CNT_W(CW), .PRE_W(12), .SYNC_STAGES(2), .ADDR_W(4)) u_tick_compare_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .fast_tick(fast_tick), .slow_tick(slow_tick), .irq(irq)
   );

   typedef struct {
      logic [3:0]  a;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;

   // monitor: compares read data against queued expectations
   always @(negedge clk) begin
      if (sb_q.size() != 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_chk++;
         if (rdata !== it.exp) begin
            n_bad++;
            $display("FAIL %s: offset %0d read %h expected %h", it.tag, it.a, rdata, it.exp);
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a[3:0]; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] e, input string tag);
      @(posedge clk); #1;
      addr = a[3:0];
      sb_q.push_back('{a[3:0], e, tag});
      @(negedge clk); #1;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      n_chk++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL %s: irq %b expected %b", tag, irq, e);
      end
   endtask

   task automatic pulse_fast(input int n);
      repeat (n) begin
         @(posedge clk); #1 fast_tick = 1'b1;
         @(posedge clk); #1 fast_tick = 1'b0;
      end
   endtask

   task automatic pulse_slow(input int n);
      repeat (n) begin
         repeat (3) @(posedge clk);
         #1 slow_tick = 1'b1;
         repeat (3) @(posedge clk);
         #1 slow_tick = 1'b0;
      end
      repeat (5) @(posedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R13 reset state
      rd(0, 32'h0, "R13 ctrl");
      rd(1, 32'h0, "R13 prescaler");
      rd(2, 32'h0, "R13 status");
      rd(3, 32'h0, "R13 ier");
      rd(4, 32'hFF, "R13 cmp1");
      rd(5, 32'hFF, "R13 cmp2");
      rd(6, 32'hFF, "R13 cmp3");
      rd(7, 32'h0, "R13 cap1");
      rd(9, 32'h0, "R13 counter");
      rd(12, 32'h0, "R1 unmapped read");
      chk_irq(1'b0, "R13 irq");

      // R2 masked control bits
      wr(0, 32'h0000_7E54);
      rd(0, 32'h0000_0240, "R2 dropped bits");
      // R4 prescaler width
      wr(1, 32'h0000_ABCD);
      rd(1, 32'h0000_0BCD, "R4 prescaler width");
      wr(1, 32'h0);

      // R5 free-run counting on fast tick
      wr(0, 32'h0000_0241);
      rd(9, 32'd0, "R11 no clear without enable mode");
      pulse_fast(5);
      rd(9, 32'd5, "R5 count five ticks");

      // R4 prescaler divides by 3
      wr(1, 32'd2);
      pulse_fast(9);
      rd(9, 32'd8, "R4 prescale by three");
      wr(1, 32'd0);

      // R3 source selection
      wr(0, 32'h0000_0201);
      pulse_fast(3);
      rd(9, 32'd8, "R3 source none holds");
      wr(0, 32'h0000_02C1);
      pulse_fast(3);
      rd(9, 32'd8, "R3 undefined code holds");
      wr(0, 32'h0000_0281);
      pulse_fast(2);
      rd(9, 32'd10, "R3 code 010 counts fast");
      wr(0, 32'h0000_0241);

      // R6 / R7 / R8 compare 2 flag
      wr(5, 32'd13);
      pulse_fast(3);
      rd(9, 32'd13, "R6 counter at cmp2");
      rd(2, 32'h02, "R6 cmp2 flag without enable");
      chk_irq(1'b0, "R8 flag not enabled");
      wr(3, 32'h02);
      chk_irq(1'b1, "R8 enabled flag");
      wr(2, 32'h01);
      rd(2, 32'h02, "R7 zero bit leaves flag");
      wr(2, 32'h02);
      rd(2, 32'h00, "R7 one clears flag");
      chk_irq(1'b0, "R8 irq after clear");

      // R8 / R11 gating by enable bit
      wr(6, 32'd15);
      wr(3, 32'h04);
      pulse_fast(2);
      rd(9, 32'd15, "R6 counter at cmp3");
      rd(2, 32'h04, "R6 cmp3 flag");
      chk_irq(1'b1, "R8 cmp3 irq");
      wr(0, 32'h0000_0240);
      chk_irq(1'b0, "R8 gated by enable");
      rd(2, 32'h04, "R8 flag kept while disabled");
      pulse_fast(3);
      rd(9, 32'd15, "R11 hold while disabled");
      wr(0, 32'h0000_0241);
      rd(9, 32'd15, "R11 resume from held value");
      chk_irq(1'b1, "R8 irq back with enable");
      wr(2, 32'h3F);
      wr(3, 32'h00);

      // R5 rollover
      pulse_fast(240);
      rd(9, 32'd255, "R5 reach all-ones");
      rd(2, 32'h01, "R6 cmp1 match at top");
      pulse_fast(1);
      rd(9, 32'd0, "R5 wrap to zero");
      rd(2, 32'h21, "R5 rollover flag");
      wr(2, 32'h3F);

      // R9 / R10 restart mode
      wr(0, 32'h0000_0041);
      pulse_fast(2);
      rd(9, 32'd2, "R9 restart mode counts");
      wr(4, 32'd4);
      rd(9, 32'd0, "R10 cmp1 write clears");
      pulse_fast(4);
      rd(9, 32'd4, "R9 reach cmp1");
      rd(2, 32'h01, "R6 cmp1 flag restart");
      pulse_fast(1);
      rd(9, 32'd0, "R9 restart to zero");
      rd(2, 32'h01, "R9 no rollover flag");
      pulse_fast(3);
      rd(9, 32'd3, "R9 counts after restart");

      // R11 enable mode
      wr(0, 32'h0000_0040);
      pulse_fast(2);
      rd(9, 32'd3, "R11 hold disabled");
      wr(0, 32'h0000_0043);
      rd(9, 32'd0, "R11 enable mode clears");
      pulse_fast(2);
      rd(9, 32'd2, "R11 counts after clear");
      wr(0, 32'h0000_0042);
      wr(0, 32'h0000_0041);
      rd(9, 32'd2, "R11 plain enable keeps count");

      // R14 slow tick
      wr(0, 32'h0000_0301);
      pulse_fast(3);
      rd(9, 32'd2, "R14 fast tick ignored");
      pulse_slow(3);
      rd(9, 32'd5, "R14 slow edges counted");

      // R1 read-only and unmapped offsets
      wr(10, 32'hFFFF_FFFF);
      wr(9, 32'h55);
      wr(7, 32'h55);
      wr(8, 32'h55);
      rd(0, 32'h0000_0301, "R1 ctrl untouched");
      rd(9, 32'd5, "R1 counter read-only");
      rd(7, 32'h0, "R1 cap1 reads zero");
      rd(8, 32'h0, "R1 cap2 reads zero");
      rd(10, 32'h0, "R1 offset 10 reads zero");
      rd(15, 32'h0, "R1 offset 15 reads zero");
      rd(1, 32'h0, "R1 prescaler untouched");
      rd(4, 32'd4, "R1 cmp1 untouched");
      rd(5, 32'd13, "R1 cmp2 untouched");
      rd(6, 32'd15, "R1 cmp3 untouched");

      // R12 software reset
      wr(1, 32'd5);
      wr(3, 32'h3F);
      chk_irq(1'b1, "R8 irq before soft reset");
      wr(0, 32'h0000_833F);
      rd(0, 32'h0000_0300, "R12 ctrl after soft reset");
      rd(0, 32'h0000_0300, "R2 reset bit self-clears");
      rd(1, 32'h0, "R12 prescaler");
      rd(2, 32'h0, "R12 status");
      rd(3, 32'h0, "R12 ier");
      rd(9, 32'h0, "R12 counter");
      rd(4, 32'hFF, "R12 cmp1");
      rd(5, 32'hFF, "R12 cmp2");
      rd(6, 32'hFF, "R12 cmp3");
      chk_irq(1'b0, "R12 irq low");

      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule